// File: doc/BRIEF.md
# Pulse-Swallow Modulus Select Controller

This block drives the modulus-select line of a dual-modulus prescaler inside an integer-N frequency divider. It runs on the prescaler output clock and holds a small up/down counter. The counter climbs from zero while the prescaler divides by its larger modulus. When the count equals an external channel code, a toggling direction flop flips. The counter is then loaded with a fixed value (28 by default) and counts down while the prescaler uses its smaller modulus. When the count meets the channel code again on the way down, the flop flips back, the counter clears to zero and the sequence repeats.

The direction bit is both the counter's up/down control and the modulus-select output. For any valid channel code the whole sequence therefore lasts a fixed number of prescaler cycles, and the channel code sets how many of those cycles use the larger modulus. The equality match is registered, so an equality that lasts several cycles flips the flop only once. Two further rules keep the count between zero and the load value: the counter turns at either bound, and a channel code above the load value raises an error flag.

Top module: `psw_modsel_ctrl`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge, sets the count to 0 and the direction to up (dir_up=1, mod_sel=1).
- R2: While counting up, with the count below the load value and not equal to the channel code, the count rises by one per clock.
- R3: While counting down, with the count above 0 and not equal to the channel code, the count falls by one per clock.
- R4: When the count equals a valid channel code while counting up, the next cycle shows direction down (dir_up=0) and a count equal to the load value (28).
- R5: When the count equals a valid channel code while counting down, the next cycle shows direction up (dir_up=1) and a count of 0.
- R6: For a channel code from 1 to 27, counted from reset, the sequence repeats every 30 clocks (load value + 2), and mod_sel is 1 for exactly code+1 of those clocks.
- R7: An equality that lasts over consecutive cycles flips the direction only once. Codes 0 and 28 therefore sweep the full range, and the sequence repeats every 58 clocks. With code 0 the first clock after reset turns the counter down to 28.
- R8: A channel code above 28 sets code_err=1 and never matches. The counter turns at 28 going up and at 0 going down, and repeats every 58 clocks. A code of 28 or less gives code_err=0.
- R9: mod_sel always equals dir_up: 1 selects the larger prescaler modulus and 0 selects the smaller one.
- R10: The count never exceeds the load value of 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_div | input | 1 | Prescaler output clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chan_code | input | 5 | Channel code compared with the count |
| mod_sel | output | 1 | Prescaler modulus select, 1 = larger modulus |
| dir_up | output | 1 | Counter direction, 1 = counting up |
| count | output | 5 | Current counter value |
| code_err | output | 1 | Channel code above the load value |

## Verification
The main sequence is run with channel codes 1, 6, 13 and 27. Every cycle is compared with the position expected in the 30-clock pattern. The small and large codes show that both turning points follow the code and not a bound, and the per-period count of mod_sel highs shows that the larger-modulus share tracks the code. Codes 0 and 28 are also run. In these cases the reload value equals the code, so a lasting equality that flipped the flop twice would show up as a pattern other than the 58-clock full sweep. Codes 30 and 31 show that the counter turns at the bounds and raises the error flag. Reset is applied from the middle of a down sweep.

// File: rtl/psw_pkg.sv
package psw_pkg;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } dir_e;

endpackage

// File: rtl/psw_match.sv
// Bit-wise equality of count against channel code, with a registered
// copy so only the first cycle of an equality yields a hit pulse.
module psw_match #(
   parameter int CNT_W    = 5,
   parameter int LOAD_VAL = 28
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] code,
   output logic             hit,
   output logic             code_bad
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOAD_VAL);

   logic [CNT_W-1:0] diff;
   logic             eq;
   logic             eq_q;

   genvar b;
   generate
      for (b = 0; b < CNT_W; b++) begin : g_bit
         assign diff[b] = cnt[b] ^ code[b];
      end
   endgenerate

   assign code_bad = (code > LIMIT);
   assign eq       = ~(|diff) & ~code_bad;
   assign hit      = eq & ~eq_q;

   always_ff @(posedge clk) begin
      if (rst) eq_q <= 1'b0;
      else     eq_q <= eq;
   end

endmodule

// File: rtl/psw_dir.sv
// Toggle flop (J and K tied): flips on each flip request.
module psw_dir
   import psw_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic flip,
   output dir_e dir_q
);
   always_ff @(posedge clk) begin
      if (rst)       dir_q <= DIR_UP;
      else if (flip) dir_q <= (dir_q == DIR_UP) ? DIR_DOWN : DIR_UP;
   end

endmodule

// File: rtl/psw_count.sv
// Up/down counter: loads LOAD_VAL when turning down, clears when turning up.
module psw_count
   import psw_pkg::*;
#(
   parameter int CNT_W    = 5,
   parameter int LOAD_VAL = 28
) (
   input  logic             clk,
   input  logic             rst,
   input  dir_e             dir,
   input  logic             flip,
   output logic             at_bound,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOAD_VAL);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO  = '0;

   assign at_bound = ((dir == DIR_UP)   && (cnt == LIMIT)) ||
                     ((dir == DIR_DOWN) && (cnt == ZERO));

   always_ff @(posedge clk) begin
      if (rst)                cnt <= ZERO;
      else if (flip)          cnt <= (dir == DIR_UP) ? LIMIT : ZERO;
      else if (dir == DIR_UP) cnt <= cnt + ONE;
      else                    cnt <= cnt - ONE;
   end

endmodule

// File: rtl/psw_modsel_ctrl.sv
module psw_modsel_ctrl
   import psw_pkg::*;
#(
   parameter int CNT_W    = 5,
   parameter int LOAD_VAL = 28
) (
   input  logic             clk_div,
   input  logic             rst,
   input  logic [CNT_W-1:0] chan_code,
   output logic             mod_sel,
   output logic             dir_up,
   output logic [CNT_W-1:0] count,
   output logic             code_err
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("psw_modsel_ctrl: CNT_W must be at least 2");
      end
      if (LOAD_VAL < 1 || LOAD_VAL >= (1 << CNT_W)) begin : g_bad_load
         $error("psw_modsel_ctrl: LOAD_VAL must fit in CNT_W bits and be nonzero");
      end
   endgenerate

   logic hit;
   logic at_bound;
   logic flip;
   dir_e dir;

   psw_match #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) u_match (
      .clk      (clk_div),
      .rst      (rst),
      .cnt      (count),
      .code     (chan_code),
      .hit      (hit),
      .code_bad (code_err)
   );

   assign flip = hit | at_bound;

   psw_dir u_dir (
      .clk   (clk_div),
      .rst   (rst),
      .flip  (flip),
      .dir_q (dir)
   );

   psw_count #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) u_count (
      .clk      (clk_div),
      .rst      (rst),
      .dir      (dir),
      .flip     (flip),
      .at_bound (at_bound),
      .cnt      (count)
   );

   assign dir_up  = (dir == DIR_UP);
   assign mod_sel = dir_up;

endmodule

// File: rtl/psw_modsel_ctrl_chk.sv
module psw_modsel_ctrl_chk #(
   parameter int CNT_W    = 5,
   parameter int LOAD_VAL = 28
) (
   input logic             clk_div,
   input logic             rst,
   input logic [CNT_W-1:0] chan_code,
   input logic             mod_sel,
   input logic             dir_up,
   input logic [CNT_W-1:0] count,
   input logic             code_err
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOAD_VAL);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   assert_reset_state_R1: assert property (@(posedge clk_div)
      rst |=> (count == '0) && dir_up);

   assert_count_up_R2: assert property (@(posedge clk_div) disable iff (rst)
      dir_up && (count != chan_code) && (count < LIMIT)
      |=> dir_up && (count == $past(count) + ONE));

   assert_count_down_R3: assert property (@(posedge clk_div) disable iff (rst)
      !dir_up && (count != chan_code) && (count != '0)
      |=> !dir_up && (count == $past(count) - ONE));

   assert_up_match_R4: assert property (@(posedge clk_div) disable iff (rst)
      dir_up && (count == chan_code) && (chan_code != '0) && !code_err && $stable(chan_code)
      |=> !dir_up && (count == LIMIT));

   assert_down_match_R5: assert property (@(posedge clk_div) disable iff (rst)
      !dir_up && (count == chan_code) && (chan_code != LIMIT) && !code_err && $stable(chan_code)
      |=> dir_up && (count == '0));

   assert_single_toggle_R7: assert property (@(posedge clk_div) disable iff (rst)
      !dir_up && (count == LIMIT) && (chan_code == LIMIT) && $stable(chan_code)
      |=> !dir_up && (count == LIMIT - ONE));

   assert_modsel_dir_R9: assert property (@(posedge clk_div) disable iff (rst)
      mod_sel == dir_up);

   assert_no_overflow_R10: assert property (@(posedge clk_div) disable iff (rst)
      count <= LIMIT);

endmodule

bind psw_modsel_ctrl psw_modsel_ctrl_chk #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) u_chk (.*);

// File: tb/psw_modsel_ctrl_test.sv
module psw_modsel_ctrl_test;
   localparam int LOADV = 28;
   localparam int VPER  = LOADV + 2;
   localparam int FPER  = 2 * (LOADV + 1);

   logic       clk_div = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] chan_code = 5'd6;
   logic       mod_sel;
   logic       dir_up;
   logic [4:0] count;
   logic       code_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk_div = ~clk_div;

   psw_modsel_ctrl uut (
      .clk_div  (clk_div),
      .rst      (rst),
      .chan_code(chan_code),
      .mod_sel  (mod_sel),
      .dir_up   (dir_up),
      .count    (count),
      .code_err (code_err)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reset with a given code, returns at the negedge where rst drops (t=0).
   task automatic apply_reset(input logic [4:0] code);
      @(negedge clk_div);
      rst = 1'b1;
      chan_code = code;
      @(posedge clk_div);
      @(posedge clk_div);
      @(negedge clk_div);
      check("R1 count", int'(count), 0);
      check("R1 dir_up", int'(dir_up), 1);
      check("R1 mod_sel", int'(mod_sel), 1);
      rst = 1'b0;
   endtask

   task automatic common_checks(input int exp_err);
      check("R9 mod_sel==dir_up", int'(mod_sel), int'(dir_up));
      check("R10 count<=28", int'(count <= 5'd28), 1);
      check("R8 code_err", int'(code_err), exp_err);
   endtask

   // Valid code 1..27: 30-clock pattern.
   task automatic run_valid(input int code, input int periods);
      int highs;
      highs = 0;
      apply_reset(5'(code));
      for (int t = 0; t < periods * VPER; t++) begin
         int p, ec, ed;
         string tag;
         if (t > 0) begin
            @(posedge clk_div);
            @(negedge clk_div);
         end
         p = t % VPER;
         if (p <= code) begin
            ec = p; ed = 1;
            tag = (p == 0 && t > 0) ? "R5" : "R2";
         end else begin
            ec = LOADV - (p - code - 1); ed = 0;
            tag = (p == code + 1) ? "R4" : "R3";
         end
         check({tag, " count"}, int'(count), ec);
         check({tag, " dir_up"}, int'(dir_up), ed);
         common_checks(0);
         if (mod_sel) highs++;
         if (p == VPER - 1) begin
            check("R6 mod_sel highs per period", highs, code + 1);
            highs = 0;
         end
      end
   endtask

   // Code 28 or invalid: full sweep starting upward.
   task automatic run_sweep(input int code, input int exp_err, input string tag);
      apply_reset(5'(code));
      for (int t = 0; t < 2 * FPER; t++) begin
         int q, ec, ed;
         if (t > 0) begin
            @(posedge clk_div);
            @(negedge clk_div);
         end
         q = t % FPER;
         if (q <= LOADV) begin ec = q; ed = 1; end
         else begin ec = FPER - 1 - q; ed = 0; end
         check({tag, " count"}, int'(count), ec);
         check({tag, " dir_up"}, int'(dir_up), ed);
         common_checks(exp_err);
      end
   endtask

   // Code 0: turns down at the first clock, then sweeps fully.
   task automatic run_zero();
      apply_reset(5'd0);
      for (int t = 0; t < 2 * FPER + 1; t++) begin
         int q, ec, ed;
         if (t > 0) begin
            @(posedge clk_div);
            @(negedge clk_div);
         end
         if (t == 0) begin ec = 0; ed = 1; end
         else begin
            q = (t - 1) % FPER;
            if (q <= LOADV) begin ec = LOADV - q; ed = 0; end
            else begin ec = q - (LOADV + 1); ed = 1; end
         end
         check("R7 code0 count", int'(count), ec);
         check("R7 code0 dir_up", int'(dir_up), ed);
         common_checks(0);
      end
   endtask

   // Reset applied while counting down.
   task automatic reset_mid_run();
      apply_reset(5'd6);
      repeat (12) @(posedge clk_div);
      @(negedge clk_div);
      check("R1 pre-reset dir_up down", int'(dir_up), 0);
      apply_reset(5'd6);
      @(posedge clk_div);
      @(negedge clk_div);
      check("R2 after reset count", int'(count), 1);
   endtask

   initial begin
      run_valid(6, 3);
      run_valid(1, 2);
      run_valid(27, 2);
      run_valid(13, 2);
      run_zero();
      run_sweep(28, 0, "R7 code28");
      run_sweep(30, 1, "R8 code30");
      run_sweep(31, 1, "R8 code31");
      reset_mid_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule